// File: doc/BRIEF.md
# Banked GPIO Controller with Lock Gate

A memory-mapped general purpose I/O block with a 32-bit word register interface. Pins come in banks of 32, and a parameter sets the bank count from 1 to 8. Pin number p belongs to bank p >> 5 and sits at bit p & 31 of that bank's registers. Each bank has output and input status views, write-one-to-set and write-one-to-clear output ports, an interrupt status register, a mask register and a mask-clear port. Each pin has its own control word that holds its direction, its edge trigger and a stored debounce setting.

A pin drives its pad only when it is an output and its bank's lock bit for it is clear. Lock registers are guarded. A write of the password word to the unlock address arms a one-shot gate. The next write to any lock register is accepted and disarms the gate. Inputs are synchronised before edge detection. All unmasked status bits combine into one interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (control bit 0 = 1), lock bits read 1, outputs read 0, mask bits read 1, interrupt status reads 0, irq is 0 and pin_oe is 0.
- R2: A write to the set port (0x40 + 4*bank) forces each bank bit written 1 to output 1. Bits written 0 are left unchanged. The output status (0x00 + 4*bank) reads back the output register.
- R3: A write to the clear port (0x60 + 4*bank) forces each bank bit written 1 to 0. Bits written 0 are left unchanged.
- R4: The control word of pin p sits at 0x100 + 4*p. Bit 0 is the direction (1 input, 0 output), bits 4:3 are the trigger and bits 8:5 are the debounce. It reads back masked to 0x1F9.
- R5: Writing 0x00A5A501 to 0x520 arms the unlock. Any other value written there disarms it. Bit 0 of a read at 0x520 shows the armed state.
- R6: A write to a lock register (0x500 + 4*bank) while armed loads that register and disarms the gate. Without arming, the write is ignored.
- R7: pin_oe for a pin is 1 exactly when its direction is output and its lock bit is 0.
- R8: Input status (0x20 + 4*bank) shows pin_in after a two-flop synchroniser, so a change is visible after two clock edges.
- R9: Trigger code 1 latches interrupt status on a rising edge, code 2 on a falling edge and code 3 on either edge. Code 0 never latches. The status bit is set on the third clock edge after the pin changes.
- R10: Writing 1s to interrupt status (0x80 + 4*bank) clears those bits. Writing 1s to mask clear (0xC0 + 4*bank) clears mask bits. The mask register (0xA0 + 4*bank) is written directly.
- R11: irq is the OR over all pins of status AND NOT mask.
- R12: pin_out carries the output register for every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | 32*BANKS | Pad inputs |
| pin_out | output | 32*BANKS | Output levels |
| pin_oe | output | 32*BANKS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the lock gate and the zero-bit set/clear rule. Ignored lock writes must leave the lock bits unchanged. A lock write must consume the arming, and a wrong password must disarm it. A set or clear write of all zeros must leave the outputs unchanged.

Only the bench's scenarios can show the other behaviours. These include the synchroniser latency, which trigger code latches which edge, the masking of interrupts, the write-one-to-clear status and the output enables across banks.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int BANKS = 2,
  parameter logic [31:0] PASSWORD = 32'h00A5A501
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [11:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [32*BANKS-1:0]   pin_in,
  output logic [32*BANKS-1:0]   pin_out,
  output logic [32*BANKS-1:0]   pin_oe,
  output logic                  irq
);
  localparam int NP = 32 * BANKS;
  localparam int PW = $clog2(NP);

  logic [NP-1:0] out_q, mask_q, stat_q, lock_q, dir_q;
  logic [NP-1:0] s1, s2, s3, hit;
  logic [1:0]    trig_q [NP];
  logic [3:0]    dbnc_q [NP];
  logic          armed_q;

  wire [9:0] word     = reg_addr[11:2];
  wire [1:0] unused_a = reg_addr[1:0];
  wire       in_low   = word < 10'h040;
  wire [2:0] grp      = word[5:3];
  wire [2:0] bank     = word[2:0];
  wire       bank_ok  = 32'(bank) < BANKS;
  wire       in_ctrl  = word >= 10'h040 && 32'(word) < 32'h40 + NP;
  wire [9:0] cword    = word - 10'h040;
  wire [PW-1:0] cidx  = cword[PW-1:0];
  wire       in_lock  = word[9:3] == 7'h28;
  wire       in_unlk  = word == 10'h148;

  logic [NP-1:0] bfield, wbits;
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bfield[b*32 +: 32] = {32{bank == 3'(b)}};
    assign wbits[b*32 +: 32]  = (bank == 3'(b)) ? reg_wdata : 32'h0;
  end

  wire wr_low = reg_wr && in_low && bank_ok;
  wire [NP-1:0] set_w  = (wr_low && grp == 3'd2) ? wbits : '0;
  wire [NP-1:0] clr_w  = (wr_low && grp == 3'd3) ? wbits : '0;
  wire [NP-1:0] sclr_w = (wr_low && grp == 3'd4) ? wbits : '0;
  wire [NP-1:0] mclr_w = (wr_low && grp == 3'd6) ? wbits : '0;
  wire          mwr    = wr_low && grp == 3'd5;
  wire          lwr    = reg_wr && in_lock && bank_ok && armed_q;

  for (genvar i = 0; i < NP; i++) begin : g_edge
    assign hit[i] = (trig_q[i][0] & s2[i] & ~s3[i]) | (trig_q[i][1] & ~s2[i] & s3[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; mask_q <= '1; stat_q <= '0; lock_q <= '1; dir_q <= '1;
      s1 <= '0; s2 <= '0; s3 <= '0; armed_q <= 1'b0;
      for (int i = 0; i < NP; i++) begin
        trig_q[i] <= 2'd0;
        dbnc_q[i] <= 4'd0;
      end
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
      out_q  <= (out_q | set_w) & ~clr_w;
      stat_q <= (stat_q & ~sclr_w) | hit;
      mask_q <= (mwr ? ((mask_q & ~bfield) | wbits) : mask_q) & ~mclr_w;
      if (lwr) lock_q <= (lock_q & ~bfield) | wbits;
      if (reg_wr && in_unlk) armed_q <= reg_wdata == PASSWORD;
      else if (reg_wr && in_lock) armed_q <= 1'b0;
      if (reg_wr && in_ctrl) begin
        dir_q[cidx]  <= reg_wdata[0];
        trig_q[cidx] <= reg_wdata[4:3];
        dbnc_q[cidx] <= reg_wdata[8:5];
      end
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (in_low && bank_ok) begin
      case (grp)
        3'd0: reg_rdata = out_q[32*bank +: 32];
        3'd1: reg_rdata = s2[32*bank +: 32];
        3'd4: reg_rdata = stat_q[32*bank +: 32];
        3'd5: reg_rdata = mask_q[32*bank +: 32];
        default: reg_rdata = 32'h0;
      endcase
    end else if (in_ctrl) begin
      reg_rdata = {23'h0, dbnc_q[cidx], trig_q[cidx], 2'b00, dir_q[cidx]};
    end else if (in_lock && bank_ok) begin
      reg_rdata = lock_q[32*bank +: 32];
    end else if (in_unlk) begin
      reg_rdata = {31'h0, armed_q};
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q & ~lock_q;
  assign irq     = |(stat_q & ~mask_q);
endmodule

module gpio_bank_ctrl_chk #(parameter int NP = 64) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [11:0]   reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          armed,
  input logic [NP-1:0] lock,
  input logic [NP-1:0] outv
);
  wire lock_a = reg_addr[11:5] == 7'h28;
  wire unlk_a = reg_addr[11:2] == 10'h148;
  wire sc_a   = reg_addr[11:8] == 4'h0 && (reg_addr[7:5] == 3'd2 || reg_addr[7:5] == 3'd3);

  // R6
  lock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && lock_a && !armed) |=> $stable(lock));
  // R6
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && lock_a && armed) |=> !armed);
  // R5
  bad_pwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && unlk_a && reg_wdata != 32'h00A5A501) |=> !armed);
  // R2
  zero_setclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sc_a && reg_wdata == 32'h0) |=> $stable(outv));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NP(NP)) chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .armed(armed_q), .lock(lock_q), .outv(out_q));

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int CLK = 10;
  localparam int NP = 64;
  localparam logic [31:0] PWD = 32'h00A5A501;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NP-1:0] pin_in = 0, pin_out, pin_oe;
  logic irq;
  int tests = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  gpio_bank_ctrl #(.BANKS(2)) uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // {write addr, write data, read addr, expected read}
  localparam logic [87:0] VEC [13] = '{
    {12'h040, 32'h000000F0, 12'h000, 32'h000000F0},  // R2
    {12'h060, 32'h00000030, 12'h000, 32'h000000C0},  // R3
    {12'h040, 32'h00000000, 12'h000, 32'h000000C0},  // R2 zeros
    {12'h044, 32'h80000001, 12'h004, 32'h80000001},  // R2 bank 1
    {12'h0C0, 32'h0000000F, 12'h0A0, 32'hFFFFFFF0},  // R10 mask clear
    {12'h104, 32'h000001E9, 12'h104, 32'h000001E9},  // R4
    {12'h108, 32'hFFFFFFFF, 12'h108, 32'h000001F9},  // R4 masked
    {12'h500, 32'h00000000, 12'h500, 32'hFFFFFFFF},  // R6 not armed
    {12'h520, PWD,          12'h520, 32'h00000001},  // R5
    {12'h500, 32'hFFFF0000, 12'h500, 32'hFFFF0000},  // R6 armed
    {12'h500, 32'h00000000, 12'h500, 32'hFFFF0000},  // R6 consumed
    {12'h520, 32'h00000123, 12'h520, 32'h00000000},  // R5 wrong value
    {12'h504, 32'h00000000, 12'h504, 32'hFFFFFFFF}   // R6 bank 1
  };

  task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(12'h000, d); chk("R1 out", d, 0);
    rd(12'h0A0, d); chk("R1 mask", d, 32'hFFFFFFFF);
    rd(12'h080, d); chk("R1 stat", d, 0);
    rd(12'h500, d); chk("R1 lock", d, 32'hFFFFFFFF);
    rd(12'h100, d); chk("R1 ctrl", d, 1);
    chk("R1 irq", irq, 0);
    chk("R1 oe", pin_oe, 0);

    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][87:76], VEC[i][75:44]);
      rd(VEC[i][43:32], d);
      chk($sformatf("vector %0d", i), d, VEC[i][31:0]);
    end

    wr(12'h108, 32'h0);
    wr(12'h140, 32'h0);
    #1 chk("R7 oe", pin_oe, 64'h4);
    chk("R12 out", pin_out, {32'h80000001, 32'h000000C0});

    @(negedge clk); pin_in[1] = 1;
    repeat (2) @(negedge clk);
    rd(12'h020, d); chk("R8 sync", d, 32'h2);
    chk("R9 not yet", irq, 0);
    @(negedge clk); #1;
    chk("R9 rise irq", irq, 1);
    rd(12'h080, d); chk("R9 rise stat", d, 32'h2);
    wr(12'h080, 32'h2); #1;
    chk("R10 w1c irq", irq, 0);
    rd(12'h080, d); chk("R10 w1c stat", d, 0);
    pin_in[1] = 0; settle();
    rd(12'h080, d); chk("R9 rise ignores fall", d, 0);

    wr(12'h10C, 32'h11);
    pin_in[3] = 1; settle();
    rd(12'h080, d); chk("R9 fall ignores rise", d, 0);
    pin_in[3] = 0; settle();
    rd(12'h080, d); chk("R9 fall stat", d, 32'h8);
    chk("R11 irq", irq, 1);
    wr(12'h080, 32'h8);

    wr(12'h114, 32'h19);
    pin_in[5] = 1; settle();
    rd(12'h080, d); chk("R9 both stat", d, 32'h20);
    chk("R11 masked", irq, 0);
    wr(12'h0A0, 32'hFFFFFFDF); #1;
    chk("R11 unmasked", irq, 1);
    rd(12'h0A0, d); chk("R10 mask write", d, 32'hFFFFFFDF);
    wr(12'h080, 32'h20);

    pin_in[0] = 1; settle(); pin_in[0] = 0; settle();
    rd(12'h080, d); chk("R9 code 0", d, 0);

    wr(12'h184, 32'h9);
    wr(12'h0C4, 32'h2);
    pin_in[33] = 1; settle();
    rd(12'h084, d); chk("R9 bank1 stat", d, 32'h2);
    chk("R11 bank1 irq", irq, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule